// File: doc/BRIEF.md
# Transmit Collision Statistics Counter Bank

This block keeps five statistics counters for the transmit side of an Ethernet MAC. The counters track frames that went out after one collision, frames that went out after several collisions, late collisions, frames dropped after too many collisions, and frames whose transmission was deferred. The transmit state machine sends single-cycle event strobes. A link-speed input selects how a late collision is counted. At 10/100 speed a late collision is also counted as an ordinary collision. At gigabit speed the transmission is aborted, so only the late-collision counter moves.

Each counter is narrow and sits zero-extended in a 32-bit register. Software reads it through a simple register port. A read returns the value and clears the counter. A counter that reaches its maximum holds there. For testing there are two control inputs. One is a write-enable level that lets register writes load a counter. The other is a one-cycle increment pulse that bumps every counter at once.

Top module: `coll_stats_bank`

## Requirements
- R1: After reset every counter reads as zero.
- R2: Counters are mapped at byte addresses 0x138 (one-collision frames), 0x13C (multi-collision frames), 0x140 (excessive-collision drops), 0x144 (late collisions) and 0x148 (deferred frames). A read of any other address returns zero, and a write to any other address changes no counter.
- R3: A counter occupies bits 9:0 of its register. Bits 31:10 always read as zero, and written values in bits 31:10 are discarded.
- R4: A read returns the counter's current value in the same cycle. The counter is zero from the next cycle on.
- R5: A counter at 1023 stays at 1023 on further increments and never wraps.
- R6: While `test_wr_en` is 1, a register write loads bits 9:0 of `reg_wdata` into the addressed counter. While it is 0, writes have no effect.
- R7: Each cycle with `test_inc` high adds one to every counter, subject to saturation. A test write in the same cycle takes priority for the counter it addresses.
- R8: Each cycle with an event strobe high adds one to its counter. Several sources reaching the same counter in one cycle add one in total.
- R9: With `gig_mode` = 0, `ev_late` increments the late counter. It also increments the one-collision counter when `late_prior` = 0, or the multi-collision counter when `late_prior` = 1.
- R10: With `gig_mode` = 1, `ev_late` increments only the late counter.
- R11: If a read and an increment hit the same counter in one cycle, the read returns the value before the increment and the counter is left at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gig_mode | input | 1 | 1 = gigabit link, 0 = 10/100 link |
| ev_single | input | 1 | Frame sent after exactly one collision |
| ev_multi | input | 1 | Frame sent after more than one collision |
| ev_late | input | 1 | Collision seen after the 512-bit slot time |
| late_prior | input | 1 | The late collision's frame already had earlier collisions |
| ev_excess | input | 1 | Frame abandoned after 16 collisions |
| ev_deferred | input | 1 | Frame transmission was deferred |
| test_wr_en | input | 1 | Test level: allow register writes to load counters |
| test_inc | input | 1 | Test pulse: increment all counters |
| reg_addr | input | 12 | Byte address of the register access |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |

## Verification
The assertions assume a few things about the inputs. Each strobe is sampled on its own clock edge. Read and write strobes come with a stable address. `late_prior` only matters while `ev_late` is high. The stimulus changes every input on the falling clock edge and holds it for whole cycles, so each strobe lasts an exact number of edges. No access is ever made to a counter and to an unmapped address in the same cycle. Saturation is reached either by preloading through a test write or by a long run of test increments. Both stay within the 10-bit range that the properties assume.

// File: rtl/coll_stats_pkg.sv
package coll_stats_pkg;

   localparam int NUM_CTR = 5;

   typedef enum int {
      CTR_SINGLE   = 0,
      CTR_MULTI    = 1,
      CTR_EXCESS   = 2,
      CTR_LATE     = 3,
      CTR_DEFERRED = 4
   } ctr_idx_e;

   // Byte offset of counter idx: base plus a fixed word stride.
   function automatic int ctr_offset(int base, int stride, int idx);
      return base + stride * idx;
   endfunction

endpackage

// File: rtl/coll_event_route.sv
module coll_event_route
   import coll_stats_pkg::*;
#(
   parameter int N = NUM_CTR
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         gig_mode,
   input  logic         ev_single,
   input  logic         ev_multi,
   input  logic         ev_late,
   input  logic         late_prior,
   input  logic         ev_excess,
   input  logic         ev_deferred,
   input  logic         test_inc,
   output logic [N-1:0] inc
);

   if (N != NUM_CTR) begin : g_bad_n
      $error("coll_event_route: N must equal NUM_CTR");
   end

   logic late_as_coll;
   logic late_first;
   logic late_again;

   // Below gigabit a late collision also counts as an ordinary collision.
   assign late_as_coll = ev_late & ~gig_mode;
   assign late_first   = late_as_coll & ~late_prior;
   assign late_again   = late_as_coll &  late_prior;

   always_comb begin
      inc               = '0;
      inc[CTR_SINGLE]   = ev_single   | late_first | test_inc;
      inc[CTR_MULTI]    = ev_multi    | late_again | test_inc;
      inc[CTR_EXCESS]   = ev_excess   | test_inc;
      inc[CTR_LATE]     = ev_late     | test_inc;
      inc[CTR_DEFERRED] = ev_deferred | test_inc;
   end

   AST_GIG_LATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (gig_mode && ev_late && !ev_single && !ev_multi && !test_inc)
         |-> (!inc[CTR_SINGLE] && !inc[CTR_MULTI] && inc[CTR_LATE])); // R10

   AST_SLOW_LATE_COUNTS_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
      (!gig_mode && ev_late)
         |-> (inc[CTR_LATE] && $countones({inc[CTR_SINGLE], inc[CTR_MULTI]}) >= 1)); // R9

endmodule

// File: rtl/coll_stat_ctr.sv
module coll_stat_ctr #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rd_hit,
   input  logic             wr_hit,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt
);

   if (CNT_W < 2) begin : g_bad_w
      $error("coll_stat_ctr: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic at_max;
   assign at_max = (cnt == CNT_MAX);

   // Priority: test write, then clear-on-read (keeping a same-cycle event),
   // then saturating increment.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (wr_hit) begin
         cnt <= wr_val;
      end else if (rd_hit) begin
         cnt <= inc ? CNT_ONE : '0;
      end else if (inc && !at_max) begin
         cnt <= cnt + CNT_ONE;
      end
   end

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (cnt == '0)); // R1

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (at_max && !wr_hit && !rd_hit) |=> (cnt == CNT_MAX)); // R5

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !wr_hit && !inc) |=> (cnt == '0)); // R4

   AST_READ_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !wr_hit && inc) |=> (cnt == CNT_ONE)); // R11

   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (cnt == $past(wr_val))); // R6

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !rd_hit && !inc) |=> $stable(cnt)); // R8

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !rd_hit && inc && !at_max) |=> (cnt == $past(cnt) + CNT_ONE)); // R8

endmodule

// File: rtl/coll_reg_decode.sv
module coll_reg_decode
   import coll_stats_pkg::*;
#(
   parameter int N         = NUM_CTR,
   parameter int CNT_W     = 10,
   parameter int REG_W     = 32,
   parameter int ADDR_W    = 12,
   parameter int BASE_OFFS = 'h138,
   parameter int STRIDE    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic                      reg_rd,
   input  logic                      reg_wr,
   input  logic [REG_W-1:0]          reg_wdata,
   input  logic                      test_wr_en,
   input  logic [N-1:0][CNT_W-1:0]   cnt_vals,
   output logic [N-1:0]              rd_hit,
   output logic [N-1:0]              wr_hit,
   output logic [CNT_W-1:0]          wr_val,
   output logic [REG_W-1:0]          reg_rdata
);

   localparam int LAST_OFFS = BASE_OFFS + STRIDE * (N - 1);

   if (CNT_W > REG_W) begin : g_bad_width
      $error("coll_reg_decode: CNT_W exceeds REG_W");
   end
   if (LAST_OFFS >= (1 << ADDR_W)) begin : g_bad_map
      $error("coll_reg_decode: register map does not fit ADDR_W");
   end
   if (STRIDE < 1) begin : g_bad_stride
      $error("coll_reg_decode: STRIDE must be positive");
   end

   logic [N-1:0]     hit;
   logic [CNT_W-1:0] sel_val;

   for (genvar i = 0; i < N; i++) begin : g_match
      localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(ctr_offset(BASE_OFFS, STRIDE, i));
      assign hit[i]    = (reg_addr == OFFS);
      assign rd_hit[i] = hit[i] & reg_rd;
      assign wr_hit[i] = hit[i] & reg_wr & test_wr_en;
   end

   assign wr_val = reg_wdata[CNT_W-1:0];

   always_comb begin
      sel_val = '0;
      for (int i = 0; i < N; i++) begin
         if (rd_hit[i]) sel_val = cnt_vals[i];
      end
   end

   if (CNT_W < REG_W) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[REG_W-1:CNT_W];
      assign reg_rdata = {{(REG_W-CNT_W){1'b0}}, sel_val};
   end else begin : g_full
      assign reg_rdata = sel_val;
   end

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R2

   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit == '0) |-> (reg_rdata == '0)); // R2

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata >> CNT_W) == '0); // R3

   AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !test_wr_en |-> (wr_hit == '0)); // R6

endmodule

// File: rtl/coll_stats_bank.sv
module coll_stats_bank
   import coll_stats_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int REG_W     = 32,
   parameter int ADDR_W    = 12,
   parameter int BASE_OFFS = 'h138,
   parameter int STRIDE    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gig_mode,
   input  logic              ev_single,
   input  logic              ev_multi,
   input  logic              ev_late,
   input  logic              late_prior,
   input  logic              ev_excess,
   input  logic              ev_deferred,
   input  logic              test_wr_en,
   input  logic              test_inc,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata
);

   localparam int N = NUM_CTR;

   logic [N-1:0]            inc;
   logic [N-1:0]            rd_hit;
   logic [N-1:0]            wr_hit;
   logic [CNT_W-1:0]        wr_val;
   logic [N-1:0][CNT_W-1:0] cnt_vals;

   coll_event_route #(.N(N)) u_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .gig_mode    (gig_mode),
      .ev_single   (ev_single),
      .ev_multi    (ev_multi),
      .ev_late     (ev_late),
      .late_prior  (late_prior),
      .ev_excess   (ev_excess),
      .ev_deferred (ev_deferred),
      .test_inc    (test_inc),
      .inc         (inc)
   );

   coll_reg_decode #(
      .N         (N),
      .CNT_W     (CNT_W),
      .REG_W     (REG_W),
      .ADDR_W    (ADDR_W),
      .BASE_OFFS (BASE_OFFS),
      .STRIDE    (STRIDE)
   ) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_rd     (reg_rd),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .test_wr_en (test_wr_en),
      .cnt_vals   (cnt_vals),
      .rd_hit     (rd_hit),
      .wr_hit     (wr_hit),
      .wr_val     (wr_val),
      .reg_rdata  (reg_rdata)
   );

   for (genvar i = 0; i < N; i++) begin : g_ctr
      coll_stat_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (inc[i]),
         .rd_hit (rd_hit[i]),
         .wr_hit (wr_hit[i]),
         .wr_val (wr_val),
         .cnt    (cnt_vals[i])
      );
   end

   AST_TEST_INC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      test_inc |-> (inc == '1)); // R7

endmodule

// File: tb/coll_stats_bank_test.sv
module coll_stats_bank_test;

   localparam int MAXV = 1023;
   localparam logic [11:0] A_SINGLE = 12'h138;
   localparam logic [11:0] A_MULTI  = 12'h13C;
   localparam logic [11:0] A_EXCESS = 12'h140;
   localparam logic [11:0] A_LATE   = 12'h144;
   localparam logic [11:0] A_DEFER  = 12'h148;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gig_mode = 1'b0;
   logic        ev_single = 1'b0, ev_multi = 1'b0, ev_late = 1'b0, late_prior = 1'b0;
   logic        ev_excess = 1'b0, ev_deferred = 1'b0;
   logic        test_wr_en = 1'b0, test_inc = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_rd = 1'b0, reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   logic [11:0] addrs [5];

   always #2 clk = ~clk;

   coll_stats_bank uut (
      .clk(clk), .rst_n(rst_n), .gig_mode(gig_mode),
      .ev_single(ev_single), .ev_multi(ev_multi), .ev_late(ev_late),
      .late_prior(late_prior), .ev_excess(ev_excess), .ev_deferred(ev_deferred),
      .test_wr_en(test_wr_en), .test_inc(test_inc),
      .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic rd_chk(input logic [11:0] a, input int exp, input string tag);
      reg_addr = a;
      reg_rd   = 1'b1;
      #1;
      checks++;
      if (reg_rdata !== 32'(exp)) begin
         errors++;
         $display("FAIL %s addr=%h got=%0d expected=%0d", tag, a, reg_rdata, exp);
      end
      step();
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   // Hold the strobe selected by k for n cycles (0 single,1 multi,2 excess,4 deferred).
   task automatic pulse(input int k, input int n);
      case (k)
         0: ev_single   = 1'b1;
         1: ev_multi    = 1'b1;
         2: ev_excess   = 1'b1;
         3: ev_late     = 1'b1;
         default: ev_deferred = 1'b1;
      endcase
      repeat (n) step();
      ev_single = 1'b0; ev_multi = 1'b0; ev_excess = 1'b0;
      ev_late = 1'b0; ev_deferred = 1'b0;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      addrs[0] = A_SINGLE; addrs[1] = A_MULTI; addrs[2] = A_EXCESS;
      addrs[3] = A_LATE;   addrs[4] = A_DEFER;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1: reset state
      for (int i = 0; i < 5; i++) rd_chk(addrs[i], 0, "R1 reset");

      // R8 / R4: each strobe, several burst lengths; read then re-read zero
      gig_mode = 1'b1;
      for (int i = 0; i < 5; i++) begin
         for (int n = 1; n <= 7; n += 3) begin
            pulse(i, n);
            rd_chk(addrs[i], n, "R8 count");
            rd_chk(addrs[i], 0, "R4 clear");
         end
      end
      // late strobe in gigabit also left single/multi at zero: R10
      rd_chk(A_SINGLE, 0, "R10 single");
      rd_chk(A_MULTI,  0, "R10 multi");

      // R10: gigabit late collisions touch only the late counter
      late_prior = 1'b0; pulse(3, 5);
      rd_chk(A_LATE, 5, "R10 late");
      rd_chk(A_SINGLE, 0, "R10 single");
      rd_chk(A_MULTI,  0, "R10 multi");

      // R9: 10/100, first-collision late -> single; with prior -> multi
      gig_mode = 1'b0;
      late_prior = 1'b0; pulse(3, 3);
      late_prior = 1'b1; pulse(3, 2);
      late_prior = 1'b0;
      rd_chk(A_LATE,   5, "R9 late");
      rd_chk(A_SINGLE, 3, "R9 single");
      rd_chk(A_MULTI,  2, "R9 multi");

      // R8: two sources on one counter in one cycle count once
      ev_single = 1'b1; ev_late = 1'b1;
      repeat (4) step();
      ev_single = 1'b0; ev_late = 1'b0;
      rd_chk(A_SINGLE, 4, "R8 merged");
      rd_chk(A_LATE,   4, "R8 merged late");

      // R6: writes ignored without test enable, loaded with it; R3 upper bits
      wr(A_LATE, 32'h0000_0155);
      rd_chk(A_LATE, 0, "R6 gated");
      test_wr_en = 1'b1;
      wr(A_LATE, 32'hFFFF_F2A5);
      rd_chk(A_LATE, 'h2A5, "R3 R6 load");

      // R2: map of all offsets via distinct preloads; unmapped address
      for (int i = 0; i < 5; i++) wr(addrs[i], 32'(100 + 17 * i));
      wr(12'h14C, 32'd55);
      wr(12'h100, 32'd66);
      rd_chk(12'h14C, 0, "R2 unmapped");
      for (int i = 0; i < 5; i++) rd_chk(addrs[i], 100 + 17 * i, "R2 map");

      // R5: preload near max, then overrun by strobes
      wr(A_SINGLE, 32'd1020);
      pulse(0, 8);
      rd_chk(A_SINGLE, MAXV, "R5 saturate");

      // R7: test increment on all counters
      test_inc = 1'b1; repeat (2) step(); test_inc = 1'b0;
      for (int i = 0; i < 5; i++) rd_chk(addrs[i], 2, "R7 inc all");

      // R7: same-cycle write wins on its own counter
      reg_addr = A_MULTI; reg_wdata = 32'd7; reg_wr = 1'b1; test_inc = 1'b1;
      step();
      reg_wr = 1'b0; test_inc = 1'b0;
      for (int i = 0; i < 5; i++) rd_chk(addrs[i], (i == 1) ? 7 : 1, "R7 write priority");

      // R7 / R5: long test increment run saturates every counter
      test_inc = 1'b1; repeat (1030) step(); test_inc = 1'b0;
      for (int i = 0; i < 5; i++) rd_chk(addrs[i], MAXV, "R7 R5 sat");

      // R11: read and event together
      test_wr_en = 1'b0;
      pulse(4, 4);
      ev_deferred = 1'b1;
      rd_chk(A_DEFER, 4, "R11 pre-value");
      ev_deferred = 1'b0;
      rd_chk(A_DEFER, 1, "R11 keeps event");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule